// File: doc/BRIEF.md
# Far-End Fault Monitor with Management Status

This block watches the recovered bit stream of a 100 Mbps receiver for the far-end fault signal. A remote link partner sends this signal as repeated codes. Each code is a long run of ones closed by a single zero. The block counts the ones of each run with a small counter and tracks how many well-formed codes have arrived back to back. Once enough codes arrive, it declares a far-end fault.

The block also holds two management registers behind a simple parallel port. Control register 0 selects loopback, speed and duplex. Status register 1 carries a latched remote-fault flag and a latched-low link flag. The remote-fault flag clears when register 1 is read. While the fault persists, the flag sets again on every further code, so a MAC that polls the register keeps seeing the fault.

The MAC can place the port in internal loopback at 100 Mbps full duplex by writing 0x6100. It returns to normal 100 Mbps full duplex operation by writing 0x2100.

Top module: `fef_monitor`

## Requirements
- R1: A code is exactly `RUN_LEN` (default 84) valid-strobed ones followed by one valid-strobed zero. A zero after a shorter or longer run resets the back-to-back code count to zero. A one arriving after `RUN_LEN` ones also resets that count.
- R2: When the `CODES` (default 3) consecutive code completes, the fault is declared. Register 1 bit 4 (remote fault) reads 1 and register 1 bit 2 (link) reads 0.
- R3: A read strobe loads `rd_data` at the next clock edge. Address 0 returns the control register. Address 1 returns status: bit 4 is remote fault, bit 2 is link, and all other bits are 0. Any other address returns 0.
- R4: Reading register 1 returns the remote-fault flag and then clears it. If a fault event coincides with the read, the flag stays set.
- R5: While the fault persists, every further completed code sets the remote-fault flag again, including after a read has cleared it.
- R6: Any valid bit that breaks the pattern ends the fault. The link flag is latched-low: it reads 0 once after the fault has ended and then follows the current link.
- R7: If `link_good` is low for even one cycle, the link flag drops. It then reads 0 once before it reflects recovery.
- R8: While control bit 14 (loopback) is 1, register 1 reads bit 2 = 1 and bit 4 = 0, and the code counters are held clear. After loopback is left, `CODES` fresh codes are needed to declare a fault.
- R9: A write to address 0 stores all 16 bits, which read back unchanged. Bit 14 is loopback, bit 13 is speed select (1 = 100 Mbps) and bit 8 is full duplex. Writes to any other address change nothing.
- R10: Synchronous reset sets the control register to 0x2100, clears the counters and the remote-fault flag, and sets the link flag to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Strobe marking a recovered bit |
| rx_bit | input | 1 | Recovered receive bit |
| link_good | input | 1 | Receiver reports a good link |
| rd_strobe | input | 1 | Register read request |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 16 | Registered read data |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 16 | Register write data |

## Verification
The assertions check the following on every cycle:
- the control value after reset;
- that loopback forces the status flags;
- that a fault event sets the remote-fault flag;
- that a read with no coinciding event clears that flag;
- that a dropped `link_good` lowers the link flag;
- that unmapped reads return zero.

Only the bench scenarios can show the counting behaviour: which run lengths form a code, that a broken run restarts the count, the re-latching sequence across reads, the single low read of the latched link flag, and the need for fresh codes after loopback.

// File: rtl/fef_pkg.sv
package fef_pkg;
  localparam int REG_W      = 16;
  localparam int ADDR_W     = 5;
  localparam int CTRL_ADDR  = 0;
  localparam int STAT_ADDR  = 1;
  localparam int LOOP_BIT   = 14;
  localparam int SPEED_BIT  = 13;
  localparam int DUPLEX_BIT = 8;
  localparam int RF_BIT     = 4;
  localparam int LINK_BIT   = 2;
  localparam logic [REG_W-1:0] CTRL_RESET = 16'h2100;
endpackage

// File: rtl/fef_run_detector.sv
module fef_run_detector #(
  parameter int RUN_LEN = 84,
  parameter int CODES   = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic rx_valid,
  input  logic rx_bit,
  output logic fault_evt,
  output logic fault_active
);
  localparam int OW = $clog2(RUN_LEN + 2);
  localparam int CW = $clog2(CODES + 1);
  localparam logic [OW-1:0] RUN_C = OW'(RUN_LEN);
  localparam logic [OW-1:0] ONES_MAX = OW'(RUN_LEN + 1);
  localparam logic [CW-1:0] CODES_C = CW'(CODES);
  localparam logic [CW-1:0] CODES_M1 = CW'(CODES - 1);

  logic [OW-1:0] ones_q;
  logic [CW-1:0] codes_q;
  logic          evt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ones_q  <= '0;
      codes_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (rx_valid) begin
        if (rx_bit) begin
          if (ones_q != ONES_MAX) ones_q <= ones_q + 1'b1;
          if (ones_q == RUN_C) codes_q <= '0;
        end else begin
          ones_q <= '0;
          if (ones_q == RUN_C) begin
            if (codes_q != CODES_C) codes_q <= codes_q + 1'b1;
            evt_q <= (codes_q >= CODES_M1);
          end else begin
            codes_q <= '0;
          end
        end
      end
    end
  end

  assign fault_evt    = evt_q;
  assign fault_active = (codes_q == CODES_C);
endmodule

// File: rtl/fef_ctrl_reg.sv
module fef_ctrl_reg
  import fef_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl,
  output logic             loopback
);
  logic [REG_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= CTRL_RESET;
    else if (wr_en && wr_addr == ADDR_W'(CTRL_ADDR)) ctrl_q <= wr_data;
  end

  assign ctrl     = ctrl_q;
  assign loopback = ctrl_q[LOOP_BIT];
endmodule

// File: rtl/fef_status_reg.sv
module fef_status_reg (
  input  logic clk,
  input  logic rst,
  input  logic loopback,
  input  logic fault_evt,
  input  logic fault_active,
  input  logic link_good,
  input  logic stat_read,
  output logic rf_flag,
  output logic link_flag
);
  logic rf_q, link_q, link_now;

  assign link_now = link_good && !fault_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q   <= 1'b0;
      link_q <= 1'b1;
    end else if (loopback) begin
      rf_q   <= 1'b0;
      link_q <= 1'b1;
    end else begin
      if (fault_evt)      rf_q <= 1'b1;
      else if (stat_read) rf_q <= 1'b0;
      if (stat_read) link_q <= link_now;
      else           link_q <= link_q & link_now;
    end
  end

  assign rf_flag   = rf_q;
  assign link_flag = link_q;
endmodule

// File: rtl/fef_monitor.sv
module fef_monitor
  import fef_pkg::*;
#(
  parameter int RUN_LEN = 84,
  parameter int CODES   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              rx_bit,
  input  logic              link_good,
  input  logic              rd_strobe,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [REG_W-1:0]  wr_data
);
  logic [REG_W-1:0] ctrl_q;
  logic             loopback;
  logic             fault_evt, fault_active;
  logic             rf_q, link_q;
  logic             stat_read;
  logic [REG_W-1:0] stat_word, rd_mux, rd_q;

  assign stat_read = rd_strobe && (rd_addr == ADDR_W'(STAT_ADDR));

  fef_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctrl(ctrl_q), .loopback(loopback)
  );

  fef_run_detector #(.RUN_LEN(RUN_LEN), .CODES(CODES)) u_det (
    .clk(clk), .rst(rst), .clr(loopback), .rx_valid(rx_valid),
    .rx_bit(rx_bit), .fault_evt(fault_evt), .fault_active(fault_active)
  );

  fef_status_reg u_stat (
    .clk(clk), .rst(rst), .loopback(loopback), .fault_evt(fault_evt),
    .fault_active(fault_active), .link_good(link_good),
    .stat_read(stat_read), .rf_flag(rf_q), .link_flag(link_q)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[RF_BIT]   = rf_q;
    stat_word[LINK_BIT] = link_q;
    if (rd_addr == ADDR_W'(CTRL_ADDR))      rd_mux = ctrl_q;
    else if (rd_addr == ADDR_W'(STAT_ADDR)) rd_mux = stat_word;
    else                                    rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)            rd_q <= '0;
    else if (rd_strobe) rd_q <= rd_mux;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/fef_monitor_chk.sv
module fef_monitor_chk
  import fef_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              rd_strobe,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [REG_W-1:0]  rd_data,
  input logic              link_good,
  input logic [REG_W-1:0]  ctrl_q,
  input logic              fault_evt,
  input logic              rf_q,
  input logic              link_q
);
  // R10
  reset_ctrl_chk: assert property (@(posedge clk) rst |=> (ctrl_q == CTRL_RESET && !rf_q && link_q));
  // R8
  loop_force_chk: assert property (@(posedge clk) disable iff (rst) ctrl_q[LOOP_BIT] |=> (!rf_q && link_q));
  // R2
  fault_set_chk: assert property (@(posedge clk) disable iff (rst) (fault_evt && !ctrl_q[LOOP_BIT]) |=> rf_q);
  // R4
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && rd_addr == ADDR_W'(STAT_ADDR) && !fault_evt) |=> !rf_q);
  // R7
  link_drop_chk: assert property (@(posedge clk) disable iff (rst) (!link_good && !ctrl_q[LOOP_BIT]) |=> !link_q);
  // R3
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst) (rd_strobe && rd_addr > ADDR_W'(STAT_ADDR)) |=> rd_data == '0);
endmodule

bind fef_monitor fef_monitor_chk u_chk (
  .clk(clk), .rst(rst), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
  .rd_data(rd_data), .link_good(link_good), .ctrl_q(ctrl_q),
  .fault_evt(fault_evt), .rf_q(rf_q), .link_q(link_q)
);

// File: tb/test_fef_monitor.sv
module test_fef_monitor;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0, rx_bit = 1'b0, link_good = 1'b1;
  logic        rd_strobe = 1'b0, wr_en = 1'b0;
  logic [4:0]  rd_addr = '0, wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  int          n_run = 0, n_fail = 0;
  logic [15:0] d;

  always #10 clk = ~clk;

  fef_monitor i_fef_monitor (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .link_good(link_good), .rd_strobe(rd_strobe), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  // each entry: four run lengths (0 = none, each closed by a zero), expected rf, expected link
  localparam logic [33:0] VEC [8] = '{
    {8'd84, 8'd84, 8'd84, 8'd0,  1'b1, 1'b0},
    {8'd84, 8'd84, 8'd0,  8'd0,  1'b0, 1'b1},
    {8'd83, 8'd84, 8'd84, 8'd0,  1'b0, 1'b1},
    {8'd85, 8'd84, 8'd84, 8'd84, 1'b1, 1'b0},
    {8'd84, 8'd84, 8'd83, 8'd84, 1'b0, 1'b1},
    {8'd84, 8'd84, 8'd84, 8'd84, 1'b1, 1'b0},
    {8'd84, 8'd85, 8'd84, 8'd84, 1'b0, 1'b1},
    {8'd10, 8'd84, 8'd84, 8'd84, 1'b1, 1'b0}
  };

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_run(int n);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_bit = 1'b1; @(negedge clk);
    end
    rx_valid = 1'b1; rx_bit = 1'b0; @(negedge clk);
    rx_valid = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    rd_strobe = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_strobe = 1'b0;
    v = rd_data;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, R1 sequence hung");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10 reset state
    rd(5'd0, d); check("R10 ctrl reset", d, 16'h2100);
    rd(5'd1, d); check("R10 status reset", d, 16'h0004);

    // R1 R2 vector table
    for (int k = 0; k < 8; k++) begin
      do_reset();
      for (int j = 0; j < 4; j++) begin
        int len;
        len = int'(VEC[k][33 - 8*j -: 8]);
        if (len != 0) send_run(len);
      end
      rd(5'd1, d);
      check("R1/R2 vector", d, {11'd0, VEC[k][1], 1'b0, VEC[k][0], 2'b00});
    end

    // R4 clear on read, R5 re-latch
    do_reset();
    send_run(84); send_run(84); send_run(84);
    rd(5'd1, d); check("R2 fault declared", d, 16'h0010);
    rd(5'd1, d); check("R4 cleared after read", d, 16'h0000);
    send_run(84);
    rd(5'd1, d); check("R5 re-latched", d, 16'h0010);

    // R6 fault ends, link latched low
    send_run(83);
    rd(5'd1, d); check("R6 link latched low", d, 16'h0000);
    rd(5'd1, d); check("R6 link recovered", d, 16'h0004);

    // R7 link_good glitch
    link_good = 1'b0; @(negedge clk); link_good = 1'b1; @(negedge clk);
    rd(5'd1, d); check("R7 link drop latched", d, 16'h0000);
    rd(5'd1, d); check("R7 link back", d, 16'h0004);

    // R8 loopback forces status and clears counting
    send_run(84); send_run(84); send_run(84);
    wr(5'd0, 16'h6100);
    @(negedge clk);
    rd(5'd1, d); check("R8 loopback status", d, 16'h0004);
    rd(5'd0, d); check("R8 loopback ctrl", d, 16'h6100);
    send_run(84); send_run(84); send_run(84);
    rd(5'd1, d); check("R8 no fault in loopback", d, 16'h0004);
    wr(5'd0, 16'h2100);
    send_run(84);
    rd(5'd1, d); check("R8 fresh codes needed", d, 16'h0004);
    send_run(84); send_run(84);
    rd(5'd1, d); check("R8 fault after exit", d, 16'h0010);

    // R9 full readback, other addresses ignored
    wr(5'd0, 16'hA5A5);
    rd(5'd0, d); check("R9 readback", d, 16'hA5A5);
    wr(5'd2, 16'h1234);
    rd(5'd0, d); check("R9 other write ignored", d, 16'hA5A5);
    // R3 unmapped read
    rd(5'd7, d); check("R3 unmapped zero", d, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule